// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus, with both lines sampled by a faster system clock. It holds three configuration registers: a 10-bit divider word, a 9-bit mode word and a 4-bit bus word. The bus word holds a commit-control flag and a 3-bit device select. Every frame starts with an address byte. The first byte written after the address is an opcode that picks a register or asks for a commit. The following bytes are written into the selected register, most significant byte first. A read is a write frame that carries only the opcode, then a repeated START and the address with the read bit set.

The block asks an external nonvolatile store to save the registers by raising a one-cycle commit pulse after the STOP of a frame. This happens after any register write while the commit-control flag is clear, after the commit opcode, or after any write to the bus word whatever the flag holds. The save is modelled as a fixed busy interval. During that interval every address byte is refused with NACK. A new device select takes effect only after the STOP of the frame that wrote it.

Top module: `twsl_cfg_slave`

## Requirements
- R1: The slave ACKs an address byte whose top four bits are 1011 and whose next three bits equal the active device select (bit 0 is read=1, write=0). Any other address byte gets NACK and changes no register.
- R2: Opcode 0x01 selects the divider. The first data byte loads divider bits 9..2, the second byte's bits 7..6 load divider bits 1..0, and its low six bits are ignored.
- R3: Opcode 0x02 selects the mode word, output as {pdn1,pdn0,sel0,en0,p0m[1:0],p1m[1:0],div_bypass}. The first data byte's bits 6..0 load output bits 8..2, and the second byte's bits 7..6 load output bits 1..0.
- R4: Opcode 0x0D loads the bus word from data bits 3..0 as {wc, sel[2:0]}. A new select is not matched before the STOP that ends the frame: a repeated START inside the frame still answers to the old select.
- R5: After a repeated START with the read bit set, the slave sends the selected register MSB byte first. A read returns divider {div[9:2]}, then {div[1:0],000000}, and mode {0,mode[8:2]}, then {mode[1:0],000000}. The slave keeps sending while the master ACKs and releases SDA after a master NACK.
- R6: With wc=0, a frame that wrote any register produces exactly one single-cycle commit pulse after its STOP. A frame with no writes produces none.
- R7: With wc=1, register writes produce no commit pulse, and a frame carrying opcode 0x3F produces one.
- R8: A write to the bus word produces a commit pulse after the STOP, whatever the value of wc.
- R9: For COMMIT_CYCLES clocks after a commit pulse, the slave NACKs even a matching address. After that it ACKs again.
- R10: After reset the divider reads 0, the mode word reads 0x060, the bus word reads 0, the commit pulse is low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain) |
| div_cfg_o | output | 10 | Divider register |
| mode_cfg_o | output | 9 | Mode register |
| bus_cfg_o | output | 4 | Bus register {wc, sel[2:0]} |
| commit_req_o | output | 1 | One-cycle request to save all registers |

## Verification
Each line passes through a synchronizer of SYNC_STAGES flops and then an edge register. The slave therefore drives or releases SDA about four clocks after an SCL fall. The bench reads the line in the middle of the SCL high phase, sixteen clocks after that fall, so the ACK or data bit is always settled. Register outputs change about four clocks after the falling SCL edge that ends the eighth bit of a byte. The commit pulse appears about four clocks after the STOP edge. The bench checks registers and the pulse count only after its STOP task has waited a further eight clocks. For the busy window, the NACK probe finishes within about 300 clocks of the commit, far inside the interval. The ACK probe starts only after the bench has waited the full interval plus a margin.

// File: rtl/twsl_pkg.sv
package twsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } twsl_state_e;

  localparam int DIV_W  = 10;
  localparam int MODE_W = 9;
  localparam int BUSR_W = 4;

  localparam logic [7:0] OP_DIV    = 8'h01;
  localparam logic [7:0] OP_MODE   = 8'h02;
  localparam logic [7:0] OP_BUS    = 8'h0D;
  localparam logic [7:0] OP_COMMIT = 8'h3F;

  localparam logic [3:0]        DEV_CODE = 4'b1011;
  localparam logic [MODE_W-1:0] MODE_RST = 9'h060;
endpackage

// File: rtl/twsl_line_sync.sv
module twsl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], line_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign level_o = sr_q[STAGES-1];
  assign rise_o  = sr_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~sr_q[STAGES-1] & prev_q;
endmodule

// File: rtl/twsl_busy_timer.sv
module twsl_busy_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/twsl_cfg_regs.sv
module twsl_cfg_regs
  import twsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [7:0]        op_i,
  input  logic [1:0]        wr_idx_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        rd_idx_i,
  output logic [7:0]        rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [BUSR_W-1:0] bus_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_o  <= '0;
      mode_o <= MODE_RST;
      bus_o  <= '0;
    end else if (wr_en_i) begin
      case (op_i)
        OP_DIV: begin
          if (wr_idx_i == 2'd0) div_o[9:2] <= wdata_i;
          if (wr_idx_i == 2'd1) div_o[1:0] <= wdata_i[7:6];
        end
        OP_MODE: begin
          if (wr_idx_i == 2'd0) mode_o[8:2] <= wdata_i[6:0];
          if (wr_idx_i == 2'd1) mode_o[1:0] <= wdata_i[7:6];
        end
        OP_BUS: if (wr_idx_i == 2'd0) bus_o <= wdata_i[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (op_i)
      OP_DIV:  rdata_o = (rd_idx_i == 2'd0) ? div_o[9:2] :
                         (rd_idx_i == 2'd1) ? {div_o[1:0], 6'b0} : 8'h00;
      OP_MODE: rdata_o = (rd_idx_i == 2'd0) ? {1'b0, mode_o[8:2]} :
                         (rd_idx_i == 2'd1) ? {mode_o[1:0], 6'b0} : 8'h00;
      OP_BUS:  rdata_o = (rd_idx_i == 2'd0) ? {4'b0, bus_o} : 8'h00;
      default: rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/twsl_cfg_slave.sv
module twsl_cfg_slave
  import twsl_pkg::*;
#(
  parameter int COMMIT_CYCLES = 20000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [DIV_W-1:0]  div_cfg_o,
  output logic [MODE_W-1:0] mode_cfg_o,
  output logic [BUSR_W-1:0] bus_cfg_o,
  output logic              commit_req_o
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  logic start_w, stop_w, busy_w, wr_stb;
  logic [7:0] rd_byte;
  logic [1:0] rd_idx, idx_next;

  twsl_state_e state_q;
  logic [3:0]  bitcnt_q;
  logic [7:0]  rx_q, tx_q, op_q;
  logic [1:0]  idx_q;
  logic [2:0]  sel_act_q;
  logic        rd_mode_q, first_q, pend_wr_q, pend_force_q, mack_q;

  twsl_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
  twsl_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_w = scl_lvl & sda_fall;
  assign stop_w  = scl_lvl & sda_rise;

  twsl_busy_timer #(.CYCLES(COMMIT_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start_i(commit_req_o), .busy_o(busy_w));

  assign idx_next = (idx_q == 2'd3) ? 2'd3 : idx_q + 2'd1;
  assign rd_idx   = (state_q == ST_AACK) ? 2'd0 : idx_next;
  assign wr_stb   = (state_q == ST_WBYTE) && scl_fall && (bitcnt_q == 4'd8) && !first_q;

  twsl_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_stb), .op_i(op_q), .wr_idx_i(idx_q),
    .wdata_i(rx_q), .rd_idx_i(rd_idx), .rdata_o(rd_byte),
    .div_o(div_cfg_o), .mode_o(mode_cfg_o), .bus_o(bus_cfg_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;  bitcnt_q <= '0;  rx_q <= '0;  tx_q <= '0;
      op_q <= OP_DIV;      idx_q <= '0;     sel_act_q <= '0;
      rd_mode_q <= 1'b0;   first_q <= 1'b0; pend_wr_q <= 1'b0;
      pend_force_q <= 1'b0; mack_q <= 1'b0; sda_pull_o <= 1'b0;
      commit_req_o <= 1'b0;
    end else begin
      commit_req_o <= 1'b0;
      if (stop_w) begin
        state_q   <= ST_IDLE;
        sda_pull_o <= 1'b0;
        sel_act_q <= bus_cfg_o[2:0];
        if (pend_force_q || (pend_wr_q && !bus_cfg_o[3])) commit_req_o <= 1'b1;
        pend_wr_q <= 1'b0;
        pend_force_q <= 1'b0;
      end else if (start_w) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_q <= {rx_q[6:0], sda_lvl};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              if (rx_q[7:4] == DEV_CODE && rx_q[3:1] == sel_act_q && !busy_w) begin
                sda_pull_o <= 1'b1;
                rd_mode_q  <= rx_q[0];
                state_q    <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bitcnt_q <= '0;
            idx_q    <= '0;
            if (rd_mode_q) begin
              tx_q <= rd_byte;
              sda_pull_o <= ~rd_byte[7];
              state_q <= ST_RBYTE;
            end else begin
              sda_pull_o <= 1'b0;
              first_q <= 1'b1;
              state_q <= ST_WBYTE;
            end
          end
          ST_WBYTE: begin
            if (scl_rise) begin
              rx_q <= {rx_q[6:0], sda_lvl};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              sda_pull_o <= 1'b1;
              state_q <= ST_WACK;
              if (first_q) begin
                op_q <= rx_q;
                first_q <= 1'b0;
                if (rx_q == OP_COMMIT) pend_force_q <= 1'b1;
              end else begin
                idx_q <= idx_next;
                if (op_q == OP_DIV || op_q == OP_MODE || op_q == OP_BUS) pend_wr_q <= 1'b1;
                if (op_q == OP_BUS) pend_force_q <= 1'b1;
              end
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_pull_o <= 1'b0;
            bitcnt_q <= '0;
            state_q <= ST_WBYTE;
          end
          ST_RBYTE: if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              sda_pull_o <= 1'b0;
              bitcnt_q <= '0;
              state_q <= ST_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              sda_pull_o <= ~tx_q[6];
              bitcnt_q <= bitcnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack_q) begin
                idx_q <= idx_next;
                tx_q <= rd_byte;
                sda_pull_o <= ~rd_byte[7];
                state_q <= ST_RBYTE;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twsl_cfg_slave_chk.sv
module twsl_cfg_slave_chk
  import twsl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_pull,
  input twsl_state_e       state,
  input logic              busy,
  input logic              stop_det,
  input logic              commit_req,
  input logic [DIV_W-1:0]  div_cfg,
  input logic [MODE_W-1:0] mode_cfg,
  input logic [BUSR_W-1:0] bus_cfg
);
  p_reset_vals_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (div_cfg == '0 && mode_cfg == MODE_RST && bus_cfg == '0
                    && !commit_req && !sda_pull));

  p_sda_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_i);

  p_busy_nack_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK) |-> !$past(busy));

  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    commit_req |=> !commit_req);

  p_commit_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> $past(stop_det));

  p_idle_regs_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> ($stable(div_cfg) && $stable(mode_cfg) && $stable(bus_cfg)));
endmodule

bind twsl_cfg_slave twsl_cfg_slave_chk chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull(sda_pull_o), .state(state_q),
  .busy(busy_w), .stop_det(stop_w), .commit_req(commit_req_o),
  .div_cfg(div_cfg_o), .mode_cfg(mode_cfg_o), .bus_cfg(bus_cfg_o));

// File: tb/twsl_cfg_slave_tb.sv
module twsl_cfg_slave_tb_top;
  localparam int COMMIT = 3000;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [9:0] div_cfg;
  logic [8:0] mode_cfg;
  logic [3:0] bus_cfg;
  logic commit_req;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0, failures = 0, commits = 0;

  always #10 clk = ~clk;

  twsl_cfg_slave #(.COMMIT_CYCLES(COMMIT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .div_cfg_o(div_cfg), .mode_cfg_o(mode_cfg), .bus_cfg_o(bus_cfg),
    .commit_req_o(commit_req));

  always @(posedge clk) if (!rst && commit_req) commits++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask
  task automatic b_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask
  task automatic b_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); ack = ~sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask
  task automatic b_recv(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_m = 1'b1; w(Q); b = {b[6:0], sda_line}; w(Q); scl_m = 1'b0;
    end
    w(Q); sda_m = ~mack; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q); sda_m = 1'b1;
  endtask

  task automatic wr3(input logic [7:0] a, input logic [7:0] op, input logic [7:0] d0,
                     input logic [7:0] d1, input int nd);
    logic ack;
    b_start; b_send(a, ack); b_send(op, ack);
    if (nd > 0) b_send(d0, ack);
    if (nd > 1) b_send(d1, ack);
    b_stop;
  endtask

  task automatic t_reset;
    chk("R10 div", div_cfg, 0);
    chk("R10 mode", mode_cfg, 'h060);
    chk("R10 bus", bus_cfg, 0);
    chk("R10 sda released", sda_pull, 0);
    chk("R10 no commit", commits, 0);
  endtask

  task automatic t_addr;
    logic ack;
    b_start; b_send(8'hA0, ack); chk("R1 wrong code nack", ack, 0); b_stop;
    b_start; b_send(8'hB6, ack); chk("R1 wrong select nack", ack, 0);
    b_send(8'h01, ack); b_send(8'h77, ack); b_stop;
    chk("R1 no write after nack", div_cfg, 0);
    chk("R6 no commit without write", commits, 0);
  endtask

  task automatic t_div;
    logic ack;
    logic [7:0] b;
    b_start; b_send(8'hB0, ack); chk("R1 match ack", ack, 1);
    b_send(8'h01, ack); b_send(8'hAB, ack); chk("R2 data ack", ack, 1);
    b_send(8'hFF, ack); b_stop;
    chk("R2 divider value", div_cfg, 'h2AF);
    chk("R6 one commit wc=0", commits, 1);
    b_start; b_send(8'hB0, ack); chk("R9 nack while busy", ack, 0); b_stop;
    chk("R9 no extra commit", commits, 1);
    w(COMMIT + 200);
    b_start; b_send(8'hB0, ack); chk("R9 ack after busy", ack, 1);
    b_send(8'h01, ack); b_start; b_send(8'hB1, ack);
    b_recv(1'b1, b); chk("R5 div msb", b, 'hAB);
    b_recv(1'b0, b); chk("R5 div lsb", b, 'hC0);
    b_stop;
    chk("R6 read frame no commit", commits, 1);
  endtask

  task automatic t_mode;
    logic ack;
    logic [7:0] b;
    wr3(8'hB0, 8'h02, 8'h5A, 8'hC0, 2);
    chk("R3 mode fields", mode_cfg, 'h16B);
    chk("R6 mode commit", commits, 2);
    w(COMMIT + 200);
    b_start; b_send(8'hB0, ack); b_send(8'h02, ack);
    b_start; b_send(8'hB1, ack); chk("R5 read addr ack", ack, 1);
    b_recv(1'b1, b); chk("R5 mode msb", b, 'h5A);
    b_recv(1'b0, b); chk("R5 mode lsb", b, 'hC0);
    chk("R5 released after nack", sda_pull, 0);
    b_stop;
  endtask

  task automatic t_manual;
    wr3(8'hB0, 8'h0D, 8'h08, 8'h00, 1);
    chk("R8 bus write commits", commits, 3);
    chk("R4 bus value", bus_cfg, 8);
    w(COMMIT + 200);
    wr3(8'hB0, 8'h01, 8'h10, 8'h00, 2);
    chk("R7 div written wc=1", div_cfg, 'h040);
    chk("R7 no commit wc=1", commits, 3);
    wr3(8'hB0, 8'h3F, 8'h00, 8'h00, 0);
    chk("R7 commit opcode", commits, 4);
    w(COMMIT + 200);
  endtask

  task automatic t_select;
    logic ack;
    b_start; b_send(8'hB0, ack); b_send(8'h0D, ack); b_send(8'h05, ack);
    b_start; b_send(8'hB0, ack); chk("R4 old select before stop", ack, 1);
    b_stop;
    chk("R8 bus commit wc=0", commits, 5);
    w(COMMIT + 200);
    b_start; b_send(8'hB0, ack); chk("R4 old select nack", ack, 0); b_stop;
    b_start; b_send(8'hBA, ack); chk("R4 new select ack", ack, 1); b_stop;
    chk("R4 bus value", bus_cfg, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    w(5); rst = 1'b0; w(5);
    t_reset;
    t_addr;
    t_div;
    t_mode;
    t_manual;
    t_select;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule